// File: doc/BRIEF.md
# Circular Trace Capture Buffer with Scan Register Access

The block stores 32-bit trace frames in a circular RAM while capture is enabled, and gives a debug host access to its registers through a single 40-bit scan data register that a test access port controller (outside this block) shifts and updates. Each update of the scan register either writes a register or requests a read. A read is pipelined: the value arrives in the data field of the following scan. So a host ends a sequence of reads with one extra scan, usually one that addresses the identification register.

To start a capture, the host loads the post-trigger frame count, clears the write pointer and sets the enable bit. Frames then fill the ring, and the write pointer wraps at the depth. A frame marked as the trigger starts the post-trigger countdown. Acquisition stops once the programmed number of further frames is stored, which leaves the pre-trigger history in the ring. The host polls status until acquisition is complete and the staging slot is empty. It then sets the read pointer and drains the RAM through the data port, which advances the read pointer on every read.

Register map (address: meaning): 0 identification (read-only), 1 RAM depth (read-only), 2 RAM width in bits (read-only), 3 status, 4 RAM data port, 5 read pointer, 6 write pointer, 7 post-trigger frame count, 8 control. DEPTH must be a power of two.

Top module: `trace_ring_buf`

## Requirements
- R1: A scan update (`scan_upd_i` high for one cycle) takes bit 39 as the write flag (1 = write, 0 = read), bits 38:32 as the register address and bits 31:0 as the data field.
- R2: After a read scan, `scan_rdata_o` holds the addressed register's value from the next cycle until the next scan update. A write scan sets `scan_rdata_o` to 0.
- R3: A read of address 4 returns the RAM entry at the read pointer and advances the read pointer by one, modulo DEPTH.
- R4: While control bit 0 is 1 and acquisition is not complete, each cycle with `trc_valid_i` high accepts the frame. The frame is stored at the write pointer one cycle later, and the write pointer then advances modulo DEPTH.
- R5: Status bit 0 (full) becomes 1 when a frame is stored at entry DEPTH-1. It stays 1 until a control write with bit 0 set.
- R6: An accepted frame with `trc_trig_i` high sets status bit 1 (triggered). If the count register holds 0 at that moment, status bit 2 (acquisition complete) is set at once. Otherwise it is set after the count (decremented per accepted frame) is used up by that many further frames. No frame is accepted while bit 2 is set.
- R7: Status bit 3 is 1 when no accepted frame waits to be stored, and 0 in the cycle after a frame is accepted.
- R8: A control write stores data bits 1:0, and `demux_mode_o` shows bit 1. A write with bit 0 set also clears full, triggered and acquisition complete. A write of 0 stops acceptance and keeps those flags.
- R9: Addresses 0, 1 and 2 read as ID_VAL, DEPTH and 32, and writes to them are ignored.
- R10: Addresses 9 to 127 read as 0, and neither reads nor writes to them change any register. Writes to addresses 0 to 4 change nothing.
- R11: After reset, all pointers, the count and control are 0, and status reads 8.
- R12: Writes to addresses 5, 6 and 7 load the read pointer, write pointer (low log2(DEPTH) bits) and count. A host write wins over an automatic update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_upd_i | input | 1 | One-cycle update strobe of the scan register |
| scan_dr_i | input | 40 | Scan register contents: write flag, address, data |
| scan_rdata_o | output | 32 | Read-back value for the next scan's data field |
| trc_valid_i | input | 1 | A trace frame is present |
| trc_data_i | input | 32 | Trace frame |
| trc_trig_i | input | 1 | Marks the present frame as the trigger |
| demux_mode_o | output | 1 | Control bit 1, demultiplexed port mode |

## Verification
A wrong pointer or flag is never seen directly. It shows up at `scan_rdata_o` in the cycle after the scan that reads it. A wrong write pointer shows up only later, when the RAM is drained through the data port and the frames come back shifted or out of order. A countdown error shows up as a write pointer that is off by the number of extra or missing frames when status is read after completion. For this reason the bench compares the read-back port against a behavioural model on every clock, and reads the pointers and status right after each phase, so that a fault is reported within two cycles of its first visible scan.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_ID    = 7'd0,
    A_DEPTH = 7'd1,
    A_WIDTH = 7'd2,
    A_STAT  = 7'd3,
    A_DATA  = 7'd4,
    A_RPTR  = 7'd5,
    A_WPTR  = 7'd6,
    A_TCNT  = 7'd7,
    A_CTRL  = 7'd8
  } reg_addr_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } scan_word_t;

  typedef struct packed {
    logic df_empty;
    logic acq_done;
    logic triggered;
    logic full;
  } stat_t;
endpackage

// File: rtl/trb_ram.sv
module trb_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trb_capture.sv
module trb_capture
  import trb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              trig_i,
  input  logic              clr_i,
  input  logic              wp_wr_i,
  input  logic [AW-1:0]     wp_val_i,
  input  logic              tc_wr_i,
  input  logic [DATA_W-1:0] tc_val_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [AW-1:0]     wptr_o,
  output logic [DATA_W-1:0] tcnt_o,
  output stat_t             stat_o
);
  logic              stage_v_q;
  logic [DATA_W-1:0] stage_d_q;
  logic [AW-1:0]     wptr_q;
  logic [DATA_W-1:0] tcnt_q;
  logic              full_q, trig_q, acq_q;
  logic              accept, done_now;

  assign accept   = en_i && !acq_q && valid_i;
  assign done_now = accept && ((!trig_q && trig_i && tcnt_q == '0) ||
                               (trig_q && tcnt_q == DATA_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_v_q <= 1'b0;
      stage_d_q <= '0;
    end else begin
      stage_v_q <= accept;
      if (accept) stage_d_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wptr_q <= '0;
    else if (wp_wr_i)   wptr_q <= wp_val_i;
    else if (stage_v_q) wptr_q <= wptr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tcnt_q <= '0;
    else if (tc_wr_i) tcnt_q <= tc_val_i;
    else if (accept && trig_q && tcnt_q != '0) tcnt_q <= tcnt_q - DATA_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      trig_q <= 1'b0;
      acq_q  <= 1'b0;
    end else if (clr_i) begin
      full_q <= 1'b0;
      trig_q <= 1'b0;
      acq_q  <= 1'b0;
    end else begin
      if (stage_v_q && wptr_q == AW'(DEPTH - 1)) full_q <= 1'b1;
      if (accept && trig_i) trig_q <= 1'b1;
      if (done_now) acq_q <= 1'b1;
    end
  end

  assign we_o    = stage_v_q;
  assign waddr_o = wptr_q;
  assign wdata_o = stage_d_q;
  assign wptr_o  = wptr_q;
  assign tcnt_o  = tcnt_q;
  assign stat_o  = '{df_empty: !stage_v_q, acq_done: acq_q, triggered: trig_q, full: full_q};

  AST_WPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_v_q && !wp_wr_i |=> wptr_q == $past(wptr_q) + AW'(1)); // R4
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !clr_i |=> full_q); // R5
  AST_NO_ACCEPT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_q && !clr_i |=> !stage_v_q); // R6
  AST_DONE_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_q |-> trig_q); // R6
endmodule

// File: rtl/trb_host_regs.sv
module trb_host_regs
  import trb_pkg::*;
#(
  parameter int          DEPTH  = 16,
  parameter logic [31:0] ID_VAL = 32'h7B31_0A01,
  localparam int         AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  scan_word_t        dr_i,
  input  stat_t             stat_i,
  input  logic [AW-1:0]     wptr_i,
  input  logic [DATA_W-1:0] tcnt_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [AW-1:0]     rptr_o,
  output logic [1:0]        ctrl_o,
  output logic              clr_o,
  output logic              wp_wr_o,
  output logic              tc_wr_o,
  output logic [DATA_W-1:0] wr_val_o
);
  logic              rd, wr;
  logic [DATA_W-1:0] rmux, rdata_q;
  logic [AW-1:0]     rptr_q;
  logic [1:0]        ctrl_q;

  assign rd = upd_i && !dr_i.wr;
  assign wr = upd_i && dr_i.wr;

  always_comb begin
    case (dr_i.addr)
      A_ID:    rmux = ID_VAL;
      A_DEPTH: rmux = DATA_W'(DEPTH);
      A_WIDTH: rmux = DATA_W'(DATA_W);
      A_STAT:  rmux = DATA_W'(stat_i);
      A_DATA:  rmux = ram_rdata_i;
      A_RPTR:  rmux = DATA_W'(rptr_q);
      A_WPTR:  rmux = DATA_W'(wptr_i);
      A_TCNT:  rmux = tcnt_i;
      A_CTRL:  rmux = DATA_W'(ctrl_q);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rptr_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      if (rd)      rdata_q <= rmux;
      else if (wr) rdata_q <= '0;
      if (wr && dr_i.addr == A_RPTR)      rptr_q <= dr_i.data[AW-1:0];
      else if (rd && dr_i.addr == A_DATA) rptr_q <= rptr_q + AW'(1);
      if (wr && dr_i.addr == A_CTRL) ctrl_q <= dr_i.data[1:0];
    end
  end

  assign rdata_o  = rdata_q;
  assign rptr_o   = rptr_q;
  assign ctrl_o   = ctrl_q;
  assign clr_o    = wr && dr_i.addr == A_CTRL && dr_i.data[0];
  assign wp_wr_o  = wr && dr_i.addr == A_WPTR;
  assign tc_wr_o  = wr && dr_i.addr == A_TCNT;
  assign wr_val_o = dr_i.data;

  AST_RPTR_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && dr_i.addr == A_DATA |=> rptr_q == $past(rptr_q) + AW'(1)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(rdata_q)); // R2
  AST_WR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> rdata_q == '0); // R2
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
  import trb_pkg::*;
#(
  parameter int          DEPTH  = 16,  // power of two
  parameter logic [31:0] ID_VAL = 32'h7B31_0A01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scan_upd_i,
  input  logic [39:0] scan_dr_i,
  output logic [31:0] scan_rdata_o,
  input  logic        trc_valid_i,
  input  logic [31:0] trc_data_i,
  input  logic        trc_trig_i,
  output logic        demux_mode_o
);
  localparam int AW = $clog2(DEPTH);

  stat_t             stat;
  logic [AW-1:0]     wptr, rptr, waddr;
  logic [DATA_W-1:0] tcnt, ram_rdata, wdata, wr_val;
  logic [1:0]        ctrl;
  logic              clr, wp_wr, tc_wr, we;

  trb_host_regs #(.DEPTH(DEPTH), .ID_VAL(ID_VAL)) u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (scan_upd_i),
    .dr_i       (scan_word_t'(scan_dr_i)),
    .stat_i     (stat),
    .wptr_i     (wptr),
    .tcnt_i     (tcnt),
    .ram_rdata_i(ram_rdata),
    .rdata_o    (scan_rdata_o),
    .rptr_o     (rptr),
    .ctrl_o     (ctrl),
    .clr_o      (clr),
    .wp_wr_o    (wp_wr),
    .tc_wr_o    (tc_wr),
    .wr_val_o   (wr_val)
  );

  trb_capture #(.DEPTH(DEPTH)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl[0]),
    .valid_i (trc_valid_i),
    .data_i  (trc_data_i),
    .trig_i  (trc_trig_i),
    .clr_i   (clr),
    .wp_wr_i (wp_wr),
    .wp_val_i(wr_val[AW-1:0]),
    .tc_wr_i (tc_wr),
    .tc_val_i(wr_val),
    .we_o    (we),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .wptr_o  (wptr),
    .tcnt_o  (tcnt),
    .stat_o  (stat)
  );

  trb_ram #(.DEPTH(DEPTH), .DW(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(rptr),
    .rdata_o(ram_rdata)
  );

  assign demux_mode_o = ctrl[1];
endmodule

// File: tb/sim_trace_ring_buf.sv
`timescale 1ns/1ps
module sim_trace_ring_buf;
  localparam int          D   = 16;
  localparam logic [31:0] IDV = 32'h7B31_0A01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [39:0] dr = '0;
  logic [31:0] rdata;
  logic        valid = 1'b0;
  logic [31:0] tdata = '0;
  logic        trig = 1'b0;
  logic        demux;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  trace_ring_buf #(.DEPTH(D), .ID_VAL(IDV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scan_upd_i(upd), .scan_dr_i(dr),
    .scan_rdata_o(rdata), .trc_valid_i(valid), .trc_data_i(tdata),
    .trc_trig_i(trig), .demux_mode_o(demux)
  );

  // behavioural reference
  logic [31:0] m_mem [D];
  int unsigned m_rp, m_wp, m_tc;
  logic [1:0]  m_ctrl;
  bit          m_full, m_trig, m_acq, m_sv;
  logic [31:0] m_sd, m_rd;

  always @(posedge clk or negedge rst_n) begin
    int unsigned n_rp, n_wp, n_tc;
    bit n_full, n_trig, n_acq, acc;
    logic [31:0] n_rd;
    logic [6:0] a;
    if (!rst_n) begin
      m_rp = 0; m_wp = 0; m_tc = 0; m_ctrl = 0;
      m_full = 0; m_trig = 0; m_acq = 0; m_sv = 0; m_sd = 0; m_rd = 0;
    end else begin
      n_rp = m_rp; n_wp = m_wp; n_tc = m_tc; n_rd = m_rd;
      n_full = m_full; n_trig = m_trig; n_acq = m_acq;
      a = dr[38:32];
      if (upd && !dr[39]) begin
        case (a)
          0: n_rd = IDV;
          1: n_rd = D;
          2: n_rd = 32;
          3: n_rd = {28'd0, !m_sv, m_acq, m_trig, m_full};
          4: begin n_rd = m_mem[m_rp]; n_rp = (m_rp + 1) % D; end
          5: n_rd = m_rp;
          6: n_rd = m_wp;
          7: n_rd = m_tc;
          8: n_rd = {30'd0, m_ctrl};
          default: n_rd = 0;
        endcase
      end else if (upd) n_rd = 0;
      if (m_sv) begin
        m_mem[m_wp] = m_sd;
        if (m_wp == D - 1) n_full = 1;
        n_wp = (m_wp + 1) % D;
      end
      acc = m_ctrl[0] && !m_acq && valid;
      if (acc) begin
        if (!m_trig && trig) begin
          n_trig = 1;
          if (m_tc == 0) n_acq = 1;
        end else if (m_trig && m_tc != 0) begin
          if (m_tc == 1) n_acq = 1;
          n_tc = m_tc - 1;
        end
        m_sd = tdata;
      end
      m_sv = acc;
      if (upd && dr[39]) begin
        if (a == 5) n_rp = dr[31:0] % D;
        if (a == 6) n_wp = dr[31:0] % D;
        if (a == 7) n_tc = dr[31:0];
        if (a == 8) begin
          m_ctrl = dr[1:0];
          if (dr[0]) begin n_full = 0; n_trig = 0; n_acq = 0; end
        end
      end
      m_rp = n_rp; m_wp = n_wp; m_tc = n_tc; m_rd = n_rd;
      m_full = n_full; m_trig = n_trig; m_acq = n_acq;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== m_rd || demux !== m_ctrl[1]) begin
        fails++;
        $display("FAIL %s model: rdata=%h demux=%b expected rdata=%h demux=%b",
                 cur_req, rdata, demux, m_rd, m_ctrl[1]);
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic scan(input bit w, input logic [6:0] a, input logic [31:0] d);
    upd = 1'b1; dr = {w, a, d};
    @(negedge clk);
    upd = 1'b0; dr = '0;
  endtask

  task automatic rd_chk(input string r, input logic [6:0] a, input logic [31:0] exp);
    scan(1'b0, a, 32'd0);
    chk(r, rdata, exp);
  endtask

  task automatic frame(input logic [31:0] d, input bit t);
    valid = 1'b1; tdata = d; trig = t;
    @(negedge clk);
    valid = 1'b0; trig = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R11";
    chk("R11", rdata, 32'd0);
    rd_chk("R11", 3, 32'd8);
    rd_chk("R11", 6, 32'd0);
    rd_chk("R11", 5, 32'd0);

    cur_req = "R9";
    rd_chk("R9", 0, IDV);
    rd_chk("R9", 1, D);
    rd_chk("R9", 2, 32'd32);
    scan(1'b1, 1, 32'd5);
    rd_chk("R9", 1, D);
    scan(1'b1, 0, 32'h1234);
    rd_chk("R9", 0, IDV);

    cur_req = "R2";
    idle(3);
    chk("R2", rdata, IDV);
    scan(1'b1, 9, 32'hFFFF_FFFF);
    chk("R2", rdata, 32'd0);

    cur_req = "R10";
    scan(1'b1, 20, 32'hFFFF_FFFF);
    rd_chk("R10", 20, 32'd0);
    rd_chk("R10", 127, 32'd0);
    scan(1'b1, 4, 32'd7);
    rd_chk("R10", 5, 32'd0);
    rd_chk("R10", 8, 32'd0);

    cur_req = "R12";
    scan(1'b1, 7, 32'd3);
    scan(1'b1, 6, 32'd0);
    scan(1'b1, 8, 32'd1);
    rd_chk("R12", 7, 32'd3);
    rd_chk("R1", 8, 32'd1);

    cur_req = "R4";
    for (int i = 0; i < 5; i++) frame(32'hA000_0000 + i, 1'b0);
    idle(1);
    rd_chk("R4", 6, 32'd5);

    cur_req = "R7";
    frame(32'hA000_0005, 1'b0);
    scan(1'b0, 3, 32'd0);
    chk("R7", rdata, 32'd0);

    cur_req = "R6";
    frame(32'hA000_0006, 1'b1);
    for (int i = 7; i < 12; i++) frame(32'hA000_0000 + i, 1'b0);
    idle(1);
    rd_chk("R6", 3, 32'd14);
    rd_chk("R6", 6, 32'd10);
    rd_chk("R6", 7, 32'd0);

    cur_req = "R3";
    scan(1'b1, 5, 32'd0);
    for (int i = 0; i < 10; i++) rd_chk("R3", 4, 32'hA000_0000 + i);
    rd_chk("R3", 5, 32'd10);

    cur_req = "R8";
    scan(1'b1, 8, 32'd0);
    frame(32'hBBBB_0000, 1'b0);
    idle(1);
    rd_chk("R8", 6, 32'd10);
    rd_chk("R8", 3, 32'd14);
    scan(1'b1, 7, 32'd0);
    scan(1'b1, 6, 32'd0);
    scan(1'b1, 8, 32'd1);
    rd_chk("R8", 3, 32'd8);

    cur_req = "R5";
    for (int i = 0; i < 20; i++) frame(32'hC000_0000 + i, 1'b0);
    idle(1);
    rd_chk("R5", 3, 32'd9);
    rd_chk("R5", 6, 32'd4);
    cur_req = "R6";
    frame(32'hC000_0014, 1'b1);
    frame(32'hC000_0015, 1'b0);
    idle(1);
    rd_chk("R6", 3, 32'd15);
    rd_chk("R6", 6, 32'd5);

    cur_req = "R3";
    scan(1'b1, 5, 32'd5);
    for (int j = 0; j < 16; j++) rd_chk("R3", 4, 32'hC000_0005 + j);
    rd_chk("R3", 5, 32'd5);

    cur_req = "R10";
    scan(1'b0, 50, 32'd0);
    rd_chk("R10", 5, 32'd5);

    cur_req = "R8";
    scan(1'b1, 8, 32'd2);
    chk("R8", {31'd0, demux}, 32'd1);
    rd_chk("R8", 8, 32'd2);
    rd_chk("R8", 3, 32'd15);
    scan(1'b1, 8, 32'd3);
    rd_chk("R8", 3, 32'd8);
    chk("R8", {31'd0, demux}, 32'd1);

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule